// File: doc/BRIEF.md
# Soft-Start Sequencer for a Synchronous Buck Controller

This block orders the start of a voltage-mode buck converter. It waits until the supply-good flag and the enable input are both high, whichever comes last. It then runs a fixed initialization interval. During that interval the low-side gate driver is held off, so that the external setpoint network develops a clean level. At the end of the interval the block captures the overcurrent setpoint code and holds it. A short settling interval follows. After that, the block raises a digital reference code from zero to full scale, one unit at a time, advancing on pulses from the switching clock.

The number of switching ticks per reference step is derived from a parameter that selects the slow or the fast switching rate. The fast rate uses twice as many ticks per step, so the ramp lasts the same wall time at either rate. When the code reaches full scale, a done flag goes high and stays high. A one-cycle strobe arms the undervoltage and power-good logic in the same cycle, with no added wait. If either enable or supply-good drops at any point, switching stops at once. The next start repeats the whole sequence, including a fresh setpoint capture.

Top module: `softstart_sequencer`

## Requirements
- R1: While reset is asserted, and in the idle state that follows it, `ref_code`, `ls_off`, `sw_en`, `ss_done`, `prot_arm` and `ocp_setpoint` are all zero.
- R2: A start happens only when `por_ok` and `en_in` are both high in the same cycle. Either one high alone leaves `ls_off` and `sw_en` at 0.
- R3: `ls_off` (1 = low-side driver forced off) rises one cycle after the cycle in which both start conditions are first seen high. It then stays high for exactly INIT_CYC cycles.
- R4: The setpoint register reads 0 from the first initialization cycle. It captures `ocp_level` as that level stands in the last initialization cycle, so earlier values have no effect. The captured value is visible from the cycle after `ls_off` falls, and it is kept while `por_ok` stays high, including while `en_in` is low.
- R5: `sw_en` (1 = switching permitted) rises exactly SETTLE_CYC cycles after `ls_off` falls.
- R6: While `sw_en` is high, `ref_code` equals min(floor(k / STEP_TICKS), REF_MAX), where k is the number of `sw_tick` pulses sampled since `sw_en` rose. Ticks at any other time are ignored, and `ref_code` is 0 whenever `sw_en` is 0.
- R7: STEP_TICKS is BASE_TPS when SW_FAST=0 and 2·BASE_TPS when SW_FAST=1. With fast ticks arriving twice as often, the ramp ends within one fast tick period of the slow configuration.
- R8: `ss_done` and `prot_arm` rise in the cycle after `ref_code` first reads REF_MAX. `prot_arm` is high for that single cycle, and `ss_done` stays high while enabled.
- R9: One cycle after `en_in` is sampled low, `sw_en`, `ls_off`, `ss_done` and `ref_code` are 0. A later release of `en_in` runs the complete sequence again, including a new capture.
- R10: One cycle after `por_ok` is sampled low, the block is idle and `ocp_setpoint` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply-good flag from the bias monitor |
| en_in | input | 1 | Converter enable, active high |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| ocp_level | input | OCP_W | Digitized overcurrent setpoint level |
| ref_code | output | REF_W | Reference code sent to the reference DAC |
| ls_off | output | 1 | Forces the low-side driver off during initialization |
| sw_en | output | 1 | Permits the modulator to switch |
| ss_done | output | 1 | Ramp finished and holding full scale |
| prot_arm | output | 1 | One-cycle strobe arming undervoltage and power-good |
| ocp_setpoint | output | OCP_W | Held overcurrent setpoint code |

## Verification
Two instances run side by side from the same supply and enable stimulus, one at each switching rate. Slow and fast tick trains come from a free-running cycle count. The reference code is predicted every cycle from the ticks counted while switching is permitted. This separates a wrong ticks-per-step ratio from a missed tick, an overshoot past full scale or a counting of ticks outside the ramp. The start-condition patterns are enable before supply-good, supply-good before enable, and both together. Each pattern has to leave the block idle or start it. Enable is removed in the running state and halfway up the ramp, and supply-good is removed during a ramp. These cases tell a full restart with a fresh capture apart from a resumed ramp, and a setpoint held across an enable drop apart from one cleared by a supply loss.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_INIT   = 3'd1,
      SQ_SETTLE = 3'd2,
      SQ_RAMP   = 3'd3,
      SQ_RUN    = 3'd4
   } seq_state_t;

endpackage

// File: rtl/ss_interval_timer.sv
module ss_interval_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] limit,
   output logic          last
);

   logic [CW-1:0] cnt_q;

   assign last = (cnt_q == (limit - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (!last)    cnt_q <= cnt_q + 1'b1;
   end

   a_r3_timer_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
   import softstart_pkg::*;
#(
   parameter int CW         = 8,
   parameter int INIT_CYC   = 16,
   parameter int SETTLE_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_ok,
   input  logic          en_in,
   input  logic          timer_last,
   input  logic          ramp_full,
   output logic          timer_clr,
   output logic [CW-1:0] timer_limit,
   output logic          sample_take,
   output logic          sample_clear,
   output logic          ramp_run,
   output logic          ramp_clr,
   output logic          ls_off,
   output logic          sw_en,
   output logic          ss_done,
   output logic          prot_arm
);

   localparam logic [CW-1:0] INIT_L   = CW'(INIT_CYC);
   localparam logic [CW-1:0] SETTLE_L = CW'(SETTLE_CYC);

   seq_state_t state_q, state_n;
   logic       arm_q;
   logic       go;

   assign go = por_ok && en_in;

   always_comb begin
      state_n = state_q;
      if (!go) begin
         state_n = SQ_IDLE;
      end else begin
         case (state_q)
            SQ_IDLE:   state_n = SQ_INIT;
            SQ_INIT:   if (timer_last) state_n = SQ_SETTLE;
            SQ_SETTLE: if (timer_last) state_n = SQ_RAMP;
            SQ_RAMP:   if (ramp_full)  state_n = SQ_RUN;
            SQ_RUN:    state_n = SQ_RUN;
            default:   state_n = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         arm_q   <= 1'b0;
      end else begin
         state_q <= state_n;
         arm_q   <= (state_q == SQ_RAMP) && (state_n == SQ_RUN);
      end
   end

   assign timer_clr    = (state_n != state_q) ||
                         !((state_q == SQ_INIT) || (state_q == SQ_SETTLE));
   assign timer_limit  = (state_q == SQ_SETTLE) ? SETTLE_L : INIT_L;
   assign sample_take  = (state_q == SQ_INIT) && (state_n == SQ_SETTLE);
   assign sample_clear = (state_q == SQ_IDLE) && (state_n == SQ_INIT);
   assign ramp_run     = (state_q == SQ_RAMP) && (state_n == SQ_RAMP);
   assign ramp_clr     = !((state_n == SQ_RAMP) || (state_n == SQ_RUN));

   assign ls_off   = (state_q == SQ_INIT);
   assign sw_en    = (state_q == SQ_RAMP) || (state_q == SQ_RUN);
   assign ss_done  = (state_q == SQ_RUN);
   assign prot_arm = arm_q;

   a_r9_enable_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_in |=> (!sw_en && !ls_off && !ss_done));

   a_r10_supply_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |=> (state_q == SQ_IDLE));

   a_r8_done_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_done) |-> $past(ramp_full));

   a_r8_arm_single: assert property (@(posedge clk) disable iff (!rst_n)
      prot_arm |=> !prot_arm);

   a_r5_ramp_follows_settle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en) |-> ($past(state_q) == SQ_SETTLE));

endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp #(
   parameter int REF_W      = 6,
   parameter int REF_MAX    = 63,
   parameter int STEP_TICKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             tick,
   output logic [REF_W-1:0] code,
   output logic             full
);

   localparam logic [REF_W-1:0] MAX_L = REF_W'(REF_MAX);

   logic [REF_W-1:0] code_q;
   logic             adv;
   logic             step;

   assign full = (code_q == MAX_L);
   assign code = code_q;
   assign adv  = run && tick && !full;

   generate
      if (STEP_TICKS == 1) begin : g_direct
         assign step = adv;
      end else begin : g_divided
         localparam int DW = $clog2(STEP_TICKS);
         localparam logic [DW-1:0] DIV_LAST = DW'(STEP_TICKS - 1);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_q <= '0;
            else if (clr)      div_q <= '0;
            else if (adv)      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
         end

         assign step = adv && (div_q == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (clr)    code_q <= '0;
      else if (step)   code_q <= code_q + 1'b1;
   end

   a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((code_q != $past(code_q)) && (code_q != '0)) |-> (code_q == $past(code_q) + 1'b1));

   a_r6_idle_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(code_q));

endmodule

// File: rtl/ss_setpoint_hold.sv
module ss_setpoint_hold #(
   parameter int OCP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_ok,
   input  logic             take,
   input  logic             clear,
   input  logic [OCP_W-1:0] din,
   output logic [OCP_W-1:0] dout
);

   logic [OCP_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  held_q <= '0;
      else if (!por_ok || clear)   held_q <= '0;
      else if (take)               held_q <= din;
   end

   assign dout = held_q;

   a_r10_supply_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |=> (dout == '0));

   a_r4_capture_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      (por_ok && take && !clear) |=> (dout == $past(din)));

endmodule

// File: rtl/softstart_sequencer.sv
module softstart_sequencer
   import softstart_pkg::*;
#(
   parameter int REF_W      = 6,
   parameter int REF_MAX    = 63,
   parameter int OCP_W      = 6,
   parameter int INIT_CYC   = 400000,
   parameter int SETTLE_CYC = 80000,
   parameter int BASE_TPS   = 19,
   parameter bit SW_FAST    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_ok,
   input  logic             en_in,
   input  logic             sw_tick,
   input  logic [OCP_W-1:0] ocp_level,
   output logic [REF_W-1:0] ref_code,
   output logic             ls_off,
   output logic             sw_en,
   output logic             ss_done,
   output logic             prot_arm,
   output logic [OCP_W-1:0] ocp_setpoint
);

   localparam int STEP_TICKS = SW_FAST ? (2 * BASE_TPS) : BASE_TPS;
   localparam int LONGEST    = (INIT_CYC > SETTLE_CYC) ? INIT_CYC : SETTLE_CYC;
   localparam int CW         = $clog2(LONGEST + 1);

   generate
      if (INIT_CYC < 2) begin : g_bad_init
         $error("softstart_sequencer: INIT_CYC must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("softstart_sequencer: SETTLE_CYC must be at least 1");
      end
      if ((REF_MAX < 1) || (REF_MAX > (2 ** REF_W) - 1)) begin : g_bad_ref
         $error("softstart_sequencer: REF_MAX must fit in REF_W bits and be nonzero");
      end
      if (BASE_TPS < 1) begin : g_bad_tps
         $error("softstart_sequencer: BASE_TPS must be at least 1");
      end
   endgenerate

   logic          timer_clr;
   logic [CW-1:0] timer_limit;
   logic          timer_last;
   logic          sample_take;
   logic          sample_clear;
   logic          ramp_run;
   logic          ramp_clr;
   logic          ramp_full;

   ss_phase_fsm #(
      .CW         (CW),
      .INIT_CYC   (INIT_CYC),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .por_ok       (por_ok),
      .en_in        (en_in),
      .timer_last   (timer_last),
      .ramp_full    (ramp_full),
      .timer_clr    (timer_clr),
      .timer_limit  (timer_limit),
      .sample_take  (sample_take),
      .sample_clear (sample_clear),
      .ramp_run     (ramp_run),
      .ramp_clr     (ramp_clr),
      .ls_off       (ls_off),
      .sw_en        (sw_en),
      .ss_done      (ss_done),
      .prot_arm     (prot_arm)
   );

   ss_interval_timer #(
      .CW (CW)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (timer_clr),
      .limit (timer_limit),
      .last  (timer_last)
   );

   ss_ref_ramp #(
      .REF_W      (REF_W),
      .REF_MAX    (REF_MAX),
      .STEP_TICKS (STEP_TICKS)
   ) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ramp_run),
      .clr   (ramp_clr),
      .tick  (sw_tick),
      .code  (ref_code),
      .full  (ramp_full)
   );

   ss_setpoint_hold #(
      .OCP_W (OCP_W)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .por_ok (por_ok),
      .take   (sample_take),
      .clear  (sample_clear),
      .din    (ocp_level),
      .dout   (ocp_setpoint)
   );

   a_r3_no_switch_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
      ls_off |-> (!sw_en && (ref_code == '0)));

   a_r8_done_holds_full: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done |-> (ref_code == REF_W'(REF_MAX)));

endmodule

// File: tb/softstart_sequencer_bench.sv
module softstart_sequencer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int INIT_C     = 20;
   localparam int SETTLE_C   = 4;
   localparam int RW         = 4;
   localparam int RMAX       = 15;
   localparam int BTPS       = 2;
   localparam int OW         = 6;
   localparam int TPS_S      = BTPS;
   localparam int TPS_F      = 2 * BTPS;
   localparam int SLOW_GAP   = 4;
   localparam int FAST_GAP   = 2;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          rst_n, por_ok, en_in;
   logic          tick_s = 1'b0, tick_f = 1'b0;
   logic [OW-1:0] ocp_lvl;
   logic [RW-1:0] ref_s, ref_f;
   logic          ls_off_s, ls_off_f, sw_en_s, sw_en_f;
   logic          done_s, done_f, arm_s, arm_f;
   logic [OW-1:0] set_s, set_f;

   softstart_sequencer #(
      .REF_W(RW), .REF_MAX(RMAX), .OCP_W(OW), .INIT_CYC(INIT_C),
      .SETTLE_CYC(SETTLE_C), .BASE_TPS(BTPS), .SW_FAST(1'b0)
   ) u_softstart_sequencer (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_in(en_in), .sw_tick(tick_s),
      .ocp_level(ocp_lvl), .ref_code(ref_s), .ls_off(ls_off_s), .sw_en(sw_en_s),
      .ss_done(done_s), .prot_arm(arm_s), .ocp_setpoint(set_s)
   );

   softstart_sequencer #(
      .REF_W(RW), .REF_MAX(RMAX), .OCP_W(OW), .INIT_CYC(INIT_C),
      .SETTLE_CYC(SETTLE_C), .BASE_TPS(BTPS), .SW_FAST(1'b1)
   ) u_softstart_sequencer_fast (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_in(en_in), .sw_tick(tick_f),
      .ocp_level(ocp_lvl), .ref_code(ref_f), .ls_off(ls_off_f), .sw_en(sw_en_f),
      .ss_done(done_f), .prot_arm(arm_f), .ocp_setpoint(set_f)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ramp_expect(input int k, input int tps);
      int v;
      v = k / tps;
      return (v > RMAX) ? RMAX : v;
   endfunction

   // per-cycle reference model for both rates: R6, R8 and shared R3 timing
   int            cyc = 0;
   int            cnt_s = 0, cnt_f = 0;
   logic          done_s_d = 1'b0, done_f_d = 1'b0;
   logic [RW-1:0] ref_s_d = '0, ref_f_d = '0;

   always @(negedge clk) begin
      int es, ef;
      if (rst_n && !finished) begin
         es = sw_en_s ? ramp_expect(cnt_s, TPS_S) : 0;
         ef = sw_en_f ? ramp_expect(cnt_f, TPS_F) : 0;
         check(int'(ref_s) == es, "R6", "slow ref_code", int'(ref_s), es);
         check(int'(ref_f) == ef, "R6", "fast ref_code", int'(ref_f), ef);
         check(ls_off_s == ls_off_f, "R3", "ls_off equal across rates", int'(ls_off_f), int'(ls_off_s));
         if (done_s && !done_s_d)
            check(int'(ref_s_d) == RMAX, "R8", "slow ref one cycle before done", int'(ref_s_d), RMAX);
         if (done_f && !done_f_d)
            check(int'(ref_f_d) == RMAX, "R8", "fast ref one cycle before done", int'(ref_f_d), RMAX);
         check(arm_s == (done_s && !done_s_d), "R8", "slow prot_arm strobe", int'(arm_s), int'(done_s && !done_s_d));
         check(arm_f == (done_f && !done_f_d), "R8", "fast prot_arm strobe", int'(arm_f), int'(done_f && !done_f_d));
      end
      done_s_d = done_s;
      done_f_d = done_f;
      ref_s_d  = ref_s;
      ref_f_d  = ref_f;
      cyc++;
      tick_s = ((cyc % SLOW_GAP) == 0);
      tick_f = ((cyc % FAST_GAP) == 0);
      if (!sw_en_s) cnt_s = 0; else if (tick_s) cnt_s++;
      if (!sw_en_f) cnt_f = 0; else if (tick_f) cnt_f++;
   end

   task automatic run_init(input int v);
      int n, m;
      @(negedge clk);
      check(ls_off_s == 1'b1, "R3", "ls_off one cycle after start", int'(ls_off_s), 1);
      check(int'(set_s) == 0, "R4", "setpoint cleared at init start", int'(set_s), 0);
      ocp_lvl = OW'(v);
      n = 1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (ls_off_s) n++;
         else break;
      end
      check(n == INIT_C, "R3", "ls_off length", n, INIT_C);
      check(int'(set_s) == v, "R4", "captured setpoint slow", int'(set_s), v);
      check(int'(set_f) == v, "R4", "captured setpoint fast", int'(set_f), v);
      m = 1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!sw_en_s) m++;
         else break;
      end
      check(m == SETTLE_C, "R5", "settle length", m, SETTLE_C);
   endtask

   task automatic run_ramp();
      int k, ts, tf, d;
      ts = -1; tf = -1; k = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         k++;
         if (done_s && ts < 0) ts = k;
         if (done_f && tf < 0) tf = k;
         if (ts >= 0 && tf >= 0) break;
      end
      check(ts > 0, "R8", "slow ramp reached done", ts, 1);
      check(tf > 0, "R8", "fast ramp reached done", tf, 1);
      d = (ts > tf) ? ts - tf : tf - ts;
      check(d <= FAST_GAP, "R7", "ramp length difference slow vs fast", d, FAST_GAP);
      repeat (5) @(negedge clk);
      check(done_s && done_f, "R8", "done stays high", int'(done_s && done_f), 1);
      check(int'(ref_s) == RMAX, "R8", "ref holds full scale", int'(ref_s), RMAX);
   endtask

   initial begin
      rst_n = 1'b0; por_ok = 1'b0; en_in = 1'b0; ocp_lvl = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ref_s == '0 && ref_f == '0, "R1", "ref_code in reset", int'(ref_s), 0);
      check(!ls_off_s && !sw_en_s, "R1", "drivers idle in reset", int'(ls_off_s || sw_en_s), 0);
      check(!done_s && !arm_s, "R1", "done/arm in reset", int'(done_s || arm_s), 0);
      check(set_s == '0, "R1", "setpoint in reset", int'(set_s), 0);
      rst_n = 1'b1;
      // R2: enable alone, then supply alone
      en_in = 1'b1; ocp_lvl = 6'd50;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!ls_off_s && !sw_en_s, "R2", "enable without supply-good", int'(ls_off_s || sw_en_s), 0);
      end
      check(set_s == '0, "R1", "setpoint idle after reset", int'(set_s), 0);
      en_in = 1'b0; por_ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!ls_off_s && !sw_en_s, "R2", "supply-good without enable", int'(ls_off_s || sw_en_s), 0);
      end
      // full start
      en_in = 1'b1;
      run_init(21);
      run_ramp();
      // R9: enable drop in running state, setpoint held
      en_in = 1'b0; ocp_lvl = 6'd3;
      @(negedge clk);
      check(!sw_en_s && !done_s && !ls_off_s, "R9", "enable low stops all", int'(sw_en_s || done_s || ls_off_s), 0);
      check(ref_s == '0, "R9", "ref cleared on enable low", int'(ref_s), 0);
      repeat (3) @(negedge clk);
      check(int'(set_s) == 21, "R4", "setpoint held with enable low", int'(set_s), 21);
      en_in = 1'b1; ocp_lvl = 6'd60;
      run_init(9);
      // R9: enable drop midway up the ramp
      repeat (30) @(negedge clk);
      check(ref_s != '0, "R6", "ramp under way", int'(ref_s), 1);
      en_in = 1'b0;
      @(negedge clk);
      check(!sw_en_s && ref_s == '0, "R9", "mid-ramp enable low", int'(ref_s), 0);
      en_in = 1'b1;
      run_init(33);
      // R10: supply loss during ramp
      repeat (12) @(negedge clk);
      por_ok = 1'b0;
      @(negedge clk);
      check(int'(set_s) == 0, "R10", "setpoint cleared on supply loss", int'(set_s), 0);
      check(!sw_en_s && !ls_off_s && ref_s == '0, "R10", "idle on supply loss", int'(sw_en_s || ls_off_s), 0);
      repeat (3) @(negedge clk);
      por_ok = 1'b1;
      run_init(44);
      run_ramp();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule